// File: doc/BRIEF.md
# Biphase Mark Audio Receiver

This block takes a biphase-mark-coded serial audio line and turns it into parallel 16-bit samples. It runs on a local clock many times faster than the line's cell rate and recovers no clock of its own. The line is first brought into the local clock domain, and its transitions are timed. Each data cell is then decided by comparing the line level just after the cell's opening transition with the level three quarters of a cell later.

Subframes are located by their sync patterns. These are runs of one and a half cells that plain biphase data never contains. A small state machine reads the sync pattern to learn the channel and whether a block starts. It then collects the 28 data cells that follow and checks their parity. If the parity is good, it presents the upper 16 bits of the 24-bit audio field with a channel tag and a one-clock strobe, ready for a serial shifter that feeds a DAC.

The nominal cell length is derived at elaboration time from the local clock frequency and a parameter that chooses between 48 kHz and 44.1 kHz streams.

Top module: `bmc_audio_rx`

## Requirements
- R1: After synchronous reset, `sample_valid`, `parity_err`, `sample_right`, `block_start` and `sample_pcm` are all 0.
- R2: Each data cell opens with a line transition. The cell decodes to 1 when the level three quarters of a cell later differs from the level just after that transition, and to 0 when the two levels are equal. A mid-cell transition is not taken as the start of a new cell.
- R3: Decoding does not depend on line polarity. The same subframe sent with the line inverted gives the same sample.
- R4: The sync run pattern, in half-cell units, sets the tags. Pattern 3,1,1,3 gives `sample_right`=0 and `block_start`=1. Pattern 3,3,1,1 gives `sample_right`=0 and `block_start`=0. Pattern 3,2,1,2 gives `sample_right`=1 and `block_start`=0.
- R5: The 28 cells after the sync pattern are, in order: 24 audio bits with the least significant bit first, then three flag bits, then a parity bit. `sample_pcm` is audio bits 23 down to 8, so `sample_pcm[0]` is audio bit 8.
- R6: Every subframe with good parity raises `sample_valid` for exactly one clock. `sample_pcm`, `sample_right` and `block_start` hold their values until the next good subframe.
- R7: Parity is even over all 28 data cells. When it fails, `parity_err` pulses for one clock, `sample_valid` stays low, and the held outputs are unchanged.
- R8: If a run of one and a half cells appears while data cells are being collected, the partial subframe is dropped without a strobe or error. That run is taken as the start of a new sync pattern, and the new subframe decodes normally.
- R9: A biphase data stream that contains no sync pattern never raises `sample_valid` or `parity_err`.
- R10: With `RATE_48K`=0 the cell timing is derived for 44.1 kHz, and a stream at that rate decodes correctly.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Local oversampling clock |
| rst | input | 1 | Synchronous active-high reset |
| bmc_in | input | 1 | Asynchronous biphase-mark serial line |
| sample_valid | output | 1 | One-clock strobe for a good subframe |
| sample_pcm | output | 16 | Upper 16 bits of the audio field |
| sample_right | output | 1 | 1 when the sample belongs to the right channel |
| block_start | output | 1 | 1 when the sample opens a block |
| parity_err | output | 1 | One-clock pulse for a subframe that fails parity |

## Verification
On every cycle, the assertions check that the strobe lasts one clock and never coincides with a parity error. They check that every strobe follows a decoded parity cell, and that the sync tracker's index stays within the pattern. They also check that a transition arriving while a cell is being timed leaves the captured reference level alone. The mapping from sync pattern to channel tag, the ordering of the audio bits, polarity independence, abandoning a subframe on a stray long run, and the 44.1 kHz timing can only be shown by the bench's directed streams, which compare decoded words against values worked out from the encoding.

// File: rtl/bmc_rx_pkg.sv
package bmc_rx_pkg;

    localparam int SLOTS    = 28;   // data cells after the sync pattern
    localparam int AUD_BITS = 24;   // audio field, LSB first
    localparam int OUT_BITS = 16;   // bits delivered

    typedef enum logic [1:0] {FS_HUNT, FS_PRE, FS_DATA} fstate_e;
    typedef enum logic [1:0] {PT_B, PT_M, PT_W} pream_e;

    // run width in half cells; 0 means out of range
    typedef logic [1:0] hcw_t;

    typedef struct packed {
        logic [OUT_BITS-1:0] pcm;
        logic                right;
        logic                blk;
    } word_t;

    function automatic int cell_clocks(int clk_hz, bit rate48);
        int fs;
        fs = rate48 ? 48000 : 44100;
        return clk_hz / (fs * 64);
    endfunction

    // expected run width of sync pattern p at position idx
    function automatic hcw_t pre_run(pream_e p, logic [1:0] idx);
        hcw_t r;
        case (idx)
            2'd1:    r = (p == PT_B) ? 2'd1 : (p == PT_M) ? 2'd3 : 2'd2;
            2'd2:    r = 2'd1;
            2'd3:    r = (p == PT_B) ? 2'd3 : (p == PT_M) ? 2'd1 : 2'd2;
            default: r = 2'd3;
        endcase
        return r;
    endfunction

endpackage

// File: rtl/bmc_sync_edge.sv
module bmc_sync_edge #(
    parameter int SYNC_STAGES = 2
) (
    input  logic clk,
    input  logic rst,
    input  logic din,
    output logic lvl_o,
    output logic edg_o
);
    logic [SYNC_STAGES:0] sh;

    always_ff @(posedge clk) begin
        if (rst) sh <= '0;
        else     sh <= {sh[SYNC_STAGES-1:0], din};
    end

    assign lvl_o = sh[SYNC_STAGES-1];
    assign edg_o = sh[SYNC_STAGES-1] ^ sh[SYNC_STAGES];
endmodule

// File: rtl/bmc_width_meter.sv
module bmc_width_meter
    import bmc_rx_pkg::*;
#(
    parameter int CELL = 16
) (
    input  logic clk,
    input  logic rst,
    input  logic edg,
    output hcw_t w_o
);
    localparam int T1 = (3 * CELL) / 4;
    localparam int T2 = (5 * CELL) / 4;
    localparam int T3 = (7 * CELL) / 4;
    localparam int CW = $clog2(T3 + 1);

    logic [CW-1:0] cnt;   // clocks since the previous transition, saturating

    always_ff @(posedge clk) begin
        if (rst)                  cnt <= CW'(T3);
        else if (edg)             cnt <= CW'(1);
        else if (cnt != CW'(T3))  cnt <= cnt + 1'b1;
    end

    always_comb begin
        if (int'(cnt) < T1)      w_o = 2'd1;
        else if (int'(cnt) < T2) w_o = 2'd2;
        else if (int'(cnt) < T3) w_o = 2'd3;
        else                     w_o = 2'd0;
    end
endmodule

// File: rtl/bmc_cell_sampler.sv
module bmc_cell_sampler #(
    parameter int CELL = 16
) (
    input  logic clk,
    input  logic rst,
    input  logic en,
    input  logic edg,
    input  logic lvl,
    output logic bit_v,
    output logic bit_d
);
    localparam int Q  = (3 * CELL) / 4;
    localparam int QW = $clog2(Q + 1);

    logic          busy;
    logic          ref_lvl;
    logic [QW-1:0] q;

    always_ff @(posedge clk) begin
        if (rst) begin
            busy    <= 1'b0;
            ref_lvl <= 1'b0;
            q       <= '0;
            bit_v   <= 1'b0;
            bit_d   <= 1'b0;
        end else begin
            bit_v <= 1'b0;
            if (!en) begin
                busy <= 1'b0;
            end else if (!busy) begin
                if (edg) begin
                    busy    <= 1'b1;
                    ref_lvl <= lvl;
                    q       <= QW'(1);
                end
            end else if (q == QW'(Q)) begin
                busy  <= 1'b0;
                bit_v <= 1'b1;
                bit_d <= lvl ^ ref_lvl;
            end else begin
                q <= q + 1'b1;
            end
        end
    end

    // R2
    ref_hold_chk: assert property (@(posedge clk) disable iff (rst)
        (busy && en && edg) |=> $stable(ref_lvl));

    // R2
    bit_src_chk: assert property (@(posedge clk) disable iff (rst)
        bit_v |-> $past(busy));
endmodule

// File: rtl/bmc_framer.sv
module bmc_framer
    import bmc_rx_pkg::*;
(
    input  logic  clk,
    input  logic  rst,
    input  logic  edg,
    input  hcw_t  w,
    input  logic  bit_v,
    input  logic  bit_d,
    output logic  dec_en,
    output word_t word_o,
    output logic  valid_o,
    output logic  err_o
);
    fstate_e             st;
    pream_e              pt;
    logic [1:0]          pidx;
    logic [4:0]          slot;
    logic [AUD_BITS-1:0] sh;
    logic                par;
    logic                arm;

    assign arm    = (st == FS_PRE) && edg && (pidx == 2'd3) && (w == pre_run(pt, 2'd3));
    assign dec_en = (st == FS_DATA) || arm;

    always_ff @(posedge clk) begin
        if (rst) begin
            st      <= FS_HUNT;
            pt      <= PT_M;
            pidx    <= '0;
            slot    <= '0;
            sh      <= '0;
            par     <= 1'b0;
            word_o  <= '0;
            valid_o <= 1'b0;
            err_o   <= 1'b0;
        end else begin
            valid_o <= 1'b0;
            err_o   <= 1'b0;
            case (st)
                FS_HUNT: begin
                    if (edg && w == 2'd3) begin
                        st   <= FS_PRE;
                        pidx <= 2'd1;
                    end
                end
                FS_PRE: begin
                    if (edg) begin
                        if (pidx == 2'd1) begin
                            pidx <= 2'd2;
                            case (w)
                                2'd1:    pt <= PT_B;
                                2'd3:    pt <= PT_M;
                                2'd2:    pt <= PT_W;
                                default: st <= FS_HUNT;
                            endcase
                        end else if (w == pre_run(pt, pidx)) begin
                            if (pidx == 2'd3) begin
                                st   <= FS_DATA;
                                slot <= '0;
                                par  <= 1'b0;
                            end
                            pidx <= pidx + 1'b1;
                        end else if (w == 2'd3) begin
                            pidx <= 2'd1;        // a fresh long run restarts the pattern
                        end else begin
                            st <= FS_HUNT;
                        end
                    end
                end
                FS_DATA: begin
                    if (edg && w == 2'd3) begin
                        st   <= FS_PRE;          // stray long run: abandon and resync
                        pidx <= 2'd1;
                    end else if (edg && w == 2'd0) begin
                        st <= FS_HUNT;
                    end else if (bit_v) begin
                        par  <= par ^ bit_d;
                        slot <= slot + 1'b1;
                        if (slot < 5'(AUD_BITS))
                            sh <= {bit_d, sh[AUD_BITS-1:1]};
                        if (slot == 5'(SLOTS - 1)) begin
                            st <= FS_HUNT;
                            if ((par ^ bit_d) == 1'b0) begin
                                valid_o      <= 1'b1;
                                word_o.pcm   <= sh[AUD_BITS-1 -: OUT_BITS];
                                word_o.right <= (pt == PT_W);
                                word_o.blk   <= (pt == PT_B);
                            end else begin
                                err_o <= 1'b1;
                            end
                        end
                    end
                end
                default: st <= FS_HUNT;
            endcase
        end
    end

    // R6
    valid_pulse_chk: assert property (@(posedge clk) disable iff (rst)
        valid_o |=> !valid_o);

    // R7
    valid_err_excl_chk: assert property (@(posedge clk) disable iff (rst)
        !(valid_o && err_o));

    // R6
    valid_src_chk: assert property (@(posedge clk) disable iff (rst)
        valid_o |-> $past(bit_v && st == FS_DATA));

    // R4
    pre_idx_chk: assert property (@(posedge clk) disable iff (rst)
        (st == FS_PRE) |-> (pidx != 2'd0));
endmodule

// File: rtl/bmc_audio_rx.sv
module bmc_audio_rx
    import bmc_rx_pkg::*;
#(
    parameter int CLK_HZ      = 50_000_000,
    parameter bit RATE_48K    = 1'b1,
    parameter int SYNC_STAGES = 2
) (
    input  logic        clk,
    input  logic        rst,
    input  logic        bmc_in,
    output logic        sample_valid,
    output logic [15:0] sample_pcm,
    output logic        sample_right,
    output logic        block_start,
    output logic        parity_err
);
    localparam int CELL = cell_clocks(CLK_HZ, RATE_48K);

    logic  lvl, edg, dec_en, bit_v, bit_d;
    hcw_t  w;
    word_t word;

    bmc_sync_edge #(.SYNC_STAGES(SYNC_STAGES)) u_sync (
        .clk(clk), .rst(rst), .din(bmc_in), .lvl_o(lvl), .edg_o(edg)
    );

    bmc_width_meter #(.CELL(CELL)) u_width (
        .clk(clk), .rst(rst), .edg(edg), .w_o(w)
    );

    bmc_cell_sampler #(.CELL(CELL)) u_cell (
        .clk(clk), .rst(rst), .en(dec_en), .edg(edg), .lvl(lvl),
        .bit_v(bit_v), .bit_d(bit_d)
    );

    bmc_framer u_frame (
        .clk(clk), .rst(rst), .edg(edg), .w(w), .bit_v(bit_v), .bit_d(bit_d),
        .dec_en(dec_en), .word_o(word), .valid_o(sample_valid), .err_o(parity_err)
    );

    assign sample_pcm   = word.pcm;
    assign sample_right = word.right;
    assign block_start  = word.blk;
endmodule

// File: tb/bmc_audio_rx_tb.sv
module bmc_audio_rx_tb;
    import bmc_rx_pkg::*;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic line = 1'b0;
    logic line44 = 1'b0;

    always #10 clk = ~clk;   // 50 MHz

    logic        v, perr, rgt, blk;
    logic [15:0] pcm;
    logic        v44, perr44, rgt44, blk44;
    logic [15:0] pcm44;

    bmc_audio_rx u_dut (
        .clk(clk), .rst(rst), .bmc_in(line),
        .sample_valid(v), .sample_pcm(pcm), .sample_right(rgt),
        .block_start(blk), .parity_err(perr)
    );

    bmc_audio_rx #(.RATE_48K(1'b0)) u_dut44 (
        .clk(clk), .rst(rst), .bmc_in(line44),
        .sample_valid(v44), .sample_pcm(pcm44), .sample_right(rgt44),
        .block_start(blk44), .parity_err(perr44)
    );

    int checks = 0;
    int errors = 0;
    int hc = 8;          // half cell in clocks
    bit use44 = 1'b0;

    int          nval = 0, nerr = 0, ndouble = 0, nval44 = 0;
    logic [17:0] vlog [64];
    logic [15:0] last44 = '0;
    logic        v_prev = 1'b0;

    always @(negedge clk) begin
        if (!rst) begin
            if (v) begin
                if (nval < 64) vlog[nval] = {blk, rgt, pcm};
                nval++;
            end
            if (perr) nerr++;
            if (v && v_prev) ndouble++;
            v_prev = v;
            if (v44) begin
                nval44++;
                last44 = pcm44;
            end
        end
    end

    task automatic chk(bit ok, string req, string what, int act, int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
        end
    endtask

    task automatic wait_c(int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic run(int n);
        if (use44) line44 = ~line44;
        else       line   = ~line;
        wait_c(n * hc);
    endtask

    task automatic send_bit(bit b);
        if (b) begin run(1); run(1); end
        else   run(2);
    endtask

    task automatic send_pre(pream_e p);
        case (p)
            PT_B:    begin run(3); run(1); run(1); run(3); end
            PT_M:    begin run(3); run(3); run(1); run(1); end
            default: begin run(3); run(2); run(1); run(2); end
        endcase
    endtask

    task automatic send_sub(pream_e p, logic [23:0] a, bit badpar);
        bit par;
        par = 1'b0;
        send_pre(p);
        for (int i = 0; i < 24; i++) begin
            send_bit(a[i]);
            par ^= a[i];
        end
        send_bit(1'b0); send_bit(1'b1); send_bit(1'b0);   // flag cells
        par ^= 1'b1;
        send_bit(par ^ badpar);
    endtask

    function automatic logic [17:0] expw(pream_e p, logic [23:0] a);
        return {p == PT_B, p == PT_W, a[23:8]};
    endfunction

    task automatic t_reset();
        wait_c(3);
        chk(v == 1'b0, "R1", "sample_valid", v, 0);
        chk(perr == 1'b0, "R1", "parity_err", perr, 0);
        chk(pcm == 16'h0, "R1", "sample_pcm", pcm, 0);
        chk({rgt, blk} == 2'b00, "R1", "tags", {rgt, blk}, 0);
    endtask

    task automatic t_stream();
        int n0;
        pream_e      ps [5];
        logic [23:0] as [5];
        ps = '{PT_B, PT_W, PT_M, PT_W, PT_M};
        as = '{24'hABCD12, 24'h5A3C99, 24'h000000, 24'hFFFFFF, 24'h800100};
        n0 = nval;
        for (int k = 0; k < 5; k++) send_sub(ps[k], as[k], 1'b0);
        wait_c(8 * hc);
        chk(nval == n0 + 5, "R6", "strobe count", nval - n0, 5);
        for (int k = 0; k < 5; k++)
            chk(vlog[n0 + k] == expw(ps[k], as[k]), "R2 R4 R5", "word",
                int'(vlog[n0 + k]), int'(expw(ps[k], as[k])));
        chk(ndouble == 0, "R6", "strobe width", ndouble, 0);
    endtask

    task automatic t_polarity();
        int n0;
        wait_c(40 * hc);
        line = ~line;
        wait_c(40 * hc);
        n0 = nval;
        send_sub(PT_M, 24'h3C5A77, 1'b0);
        send_sub(PT_W, 24'hAAAA55, 1'b0);
        wait_c(8 * hc);
        chk(nval == n0 + 2, "R3", "strobe count", nval - n0, 2);
        chk(vlog[n0] == expw(PT_M, 24'h3C5A77), "R3", "word",
            int'(vlog[n0]), int'(expw(PT_M, 24'h3C5A77)));
        chk(vlog[n0 + 1] == expw(PT_W, 24'hAAAA55), "R3", "word",
            int'(vlog[n0 + 1]), int'(expw(PT_W, 24'hAAAA55)));
    endtask

    task automatic t_parity();
        int n0, e0;
        n0 = nval; e0 = nerr;
        send_sub(PT_B, 24'h1357AC, 1'b1);
        wait_c(8 * hc);
        chk(nval == n0, "R7", "no strobe on bad parity", nval - n0, 0);
        chk(nerr == e0 + 1, "R7", "error pulses", nerr - e0, 1);
        chk({blk, rgt, pcm} == expw(PT_W, 24'hAAAA55), "R7 R6", "held word",
            int'({blk, rgt, pcm}), int'(expw(PT_W, 24'hAAAA55)));
        send_sub(PT_M, 24'h9ABC00, 1'b0);
        wait_c(8 * hc);
        chk(nval == n0 + 1, "R7", "recovery strobe", nval - n0, 1);
        chk({blk, rgt, pcm} == expw(PT_M, 24'h9ABC00), "R7", "recovery word",
            int'({blk, rgt, pcm}), int'(expw(PT_M, 24'h9ABC00)));
    endtask

    task automatic t_abort();
        int n0, e0;
        n0 = nval; e0 = nerr;
        send_pre(PT_B);
        for (int i = 0; i < 10; i++) send_bit(i[0]);
        send_sub(PT_W, 24'h2468AC, 1'b0);
        wait_c(8 * hc);
        chk(nval == n0 + 1, "R8", "strobe count", nval - n0, 1);
        chk(nerr == e0, "R8", "error count", nerr - e0, 0);
        chk(vlog[n0] == expw(PT_W, 24'h2468AC), "R8", "word",
            int'(vlog[n0]), int'(expw(PT_W, 24'h2468AC)));
    endtask

    task automatic t_nopre();
        int n0, e0;
        wait_c(40 * hc);
        n0 = nval; e0 = nerr;
        for (int i = 0; i < 96; i++) send_bit((i % 3) == 0 || (i % 7) == 2);
        wait_c(8 * hc);
        chk(nval == n0, "R9", "strobes without sync", nval - n0, 0);
        chk(nerr == e0, "R9", "errors without sync", nerr - e0, 0);
    endtask

    task automatic t_rate();
        int n0;
        use44 = 1'b1;
        hc = 9;
        n0 = nval44;
        send_sub(PT_B, 24'h0F1E2D, 1'b0);
        send_sub(PT_W, 24'hC0FFEE, 1'b0);
        wait_c(8 * hc);
        chk(nval44 == n0 + 2, "R10", "strobe count at 44.1", nval44 - n0, 2);
        chk(last44 == 16'hC0FF, "R10", "word at 44.1", last44, 16'hC0FF);
        use44 = 1'b0;
        hc = 8;
    endtask

    task automatic summary();
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
    endtask

    initial begin
        wait_c(10);
        rst = 1'b0;
        t_reset();
        t_stream();
        t_polarity();
        t_parity();
        t_abort();
        t_nopre();
        t_rate();
        summary();
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        checks++;
        errors++;
        $display("FAIL watchdog: actual %0d expected %0d", 200000, 0);
        summary();
        $finish;
    end
endmodule